// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block sits on the controller side of a 4M x 16 parallel NOR flash command bus. It observes qualified bus write cycles (word address, data word, chip/output/write enables) and follows the guarded multi-cycle command protocol. Program needs a three-cycle unlock. Erase needs a six-cycle unlock. An identification mode and a query mode are entered through a three-cycle pattern and left through an exit write. Any cycle that breaks a sequence sends the decoder back to read-array mode.

When a program or erase sequence completes, the decoder checks the target against a boot-block lockout. The lockout covers the top 32K words and is active while the write-protect pin is low. If the target is allowed, the decoder raises a one-cycle accept pulse and presents the latched target address, data and operation kind to the array sequencer downstream. An active-low reset abandons whatever sequence or operation is in progress. An operation cut off this way is not resumed and must be reissued.

Top module: `nor_cmd_decoder`

## Requirements
- R1: While or after `rstN` is low, all mode outputs (`inQuery`, `inIdMode`, `progPending`, `erasePending`) and `opAccept` are 0. A sequence cut off by reset is lost, so a later single write is not accepted as its completion.
- R2: The cycles AAh@555h, 55h@2AAh, A0h@555h set `progPending`. The next qualified write at any address clears it and produces an accept with `opKind`=0, that write's address on `opAddr` and its data on `opData`.
- R3: The cycles AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh hold `erasePending` high from the third cycle on. A sixth write of 30h at any address gives `opKind`=1 (sector) with that address. A sixth write of 10h@555h gives `opKind`=2 (chip).
- R4: A third cycle of 10h or 30h immediately after the first unlock pair does not start an erase. The decoder returns to read mode with no accept.
- R5: A write that does not match the expected cycle at any step of the unlock or erase sequences returns the decoder to read mode (all mode outputs 0). In read mode, any write other than AAh@555h leaves it in read mode.
- R6: The cycles AAh@555h, 55h@2AAh, 98h@555h set `inQuery`. With 90h as the third byte they set `inIdMode` instead.
- R7: In query or ID mode, every write whose low byte is not F0h leaves the mode unchanged. A write of F0h to any address returns to read mode.
- R8: While `wpN` is 0, a program or sector erase aimed at word addresses 3F8000h..3FFFFFh, and any chip erase, is refused: no accept, and the decoder returns to read mode. Addresses below 3F8000h, and all targets while `wpN` is 1, are accepted.
- R9: A write is taken only when `strobeValid`=1, `ceN`=0, `weN`=0 and `oeN`=1. Any other combination leaves the state unchanged and produces no accept.
- R10: `opAccept` goes high for exactly one cycle, in the cycle after the clock edge that samples the final write. Commands are compared on data bits [7:0] only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset to read mode |
| strobeValid | input | 1 | Write sample pulse; address and data are taken at this rising edge |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low (low inhibits writes) |
| weN | input | 1 | Write enable, active low |
| wpN | input | 1 | Boot-block write protect, active low |
| addr | input | 22 | Word address of the write cycle |
| data | input | 16 | Data word of the write cycle |
| inQuery | output | 1 | Query mode active |
| inIdMode | output | 1 | Identification mode active |
| progPending | output | 1 | Program unlocked, waiting for the target write |
| erasePending | output | 1 | Erase sequence past its setup cycle |
| opAccept | output | 1 | One-cycle pulse: operation accepted |
| opKind | output | 2 | 0 program, 1 sector erase, 2 chip erase |
| opAddr | output | 22 | Latched target address |
| opData | output | 16 | Latched program data |

## Verification
Every result of the decoder is registered once. A write sampled at one rising edge therefore shows its mode flags and any accept pulse, address, kind and data one edge later, and the accept pulse is gone one edge after that. The bench drives each write at a falling edge, lets exactly one rising edge pass, and compares all outputs at the next falling edge against a model it steps once per write. Idle cycles are checked the same way to confirm that nothing moves and no second accept appears.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PROG,
    ST_ERS3, ST_ERS4, ST_ERS5, ST_ID, ST_QUERY
  } seqState_t;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_CHIP   = 2'd2
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    opKind_t kind;
  } dpStrobe_t;

  // address decode results from datapath to control
  typedef struct packed {
    logic atUnlockA;
    logic atUnlockB;
    logic inBoot;
  } addrFlags_t;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_EXIT   = 8'hF0;

endpackage

// File: rtl/nor_cmd_dp.sv
module nor_cmd_dp
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int BOOT_WORDS = 32768,
  parameter int UNLOCK_A   = 'h555,
  parameter int UNLOCK_B   = 'h2AA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  dpStrobe_t         strobe,
  output addrFlags_t        flags,
  output logic [7:0]        cmdByte,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [1:0]        opKind
);

  localparam logic [ADDR_W-1:0] KEY_A_ADDR = ADDR_W'(UNLOCK_A);
  localparam logic [ADDR_W-1:0] KEY_B_ADDR = ADDR_W'(UNLOCK_B);
  localparam logic [ADDR_W-1:0] BOOT_BASE  = ADDR_W'((64'd1 << ADDR_W) - 64'(BOOT_WORDS));

  assign cmdByte         = data[7:0];
  assign flags.atUnlockA = (addr == KEY_A_ADDR);
  assign flags.atUnlockB = (addr == KEY_B_ADDR);

  generate
    if (BOOT_WORDS > 0) begin : g_boot
      assign flags.inBoot = (addr >= BOOT_BASE);
    end else begin : g_noBoot
      assign flags.inBoot = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= '0;
      opKind <= OP_PROG;
    end else if (strobe.capture) begin
      opAddr <= addr;
      opData <= data;
      opKind <= strobe.kind;
    end
  end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobeValid,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       wpN,
  input  addrFlags_t flags,
  input  logic [7:0] cmdByte,
  output dpStrobe_t  strobe,
  output logic       opAccept,
  output logic       inQuery,
  output logic       inIdMode,
  output logic       progPending,
  output logic       erasePending
);

  seqState_t state, nextState;
  logic      wrOk, locked;

  assign wrOk   = strobeValid && !ceN && !weN && oeN;
  assign locked = flags.inBoot && !wpN;

  always_comb begin
    nextState      = state;
    strobe.capture = 1'b0;
    strobe.kind    = OP_PROG;
    if (wrOk) begin
      unique case (state)
        ST_READ:  if (flags.atUnlockA && cmdByte == CMD_KEY1) nextState = ST_UNL1;
        ST_UNL1:  nextState = (flags.atUnlockB && cmdByte == CMD_KEY2) ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          nextState = ST_READ;
          if (flags.atUnlockA) begin
            unique case (cmdByte)
              CMD_PROG:   nextState = ST_PROG;
              CMD_ESETUP: nextState = ST_ERS3;
              CMD_IDENT:  nextState = ST_ID;
              CMD_QUERY:  nextState = ST_QUERY;
              default:    nextState = ST_READ;
            endcase
          end
        end
        ST_PROG: begin
          nextState      = ST_READ;
          strobe.capture = !locked;
        end
        ST_ERS3:  nextState = (flags.atUnlockA && cmdByte == CMD_KEY1) ? ST_ERS4 : ST_READ;
        ST_ERS4:  nextState = (flags.atUnlockB && cmdByte == CMD_KEY2) ? ST_ERS5 : ST_READ;
        ST_ERS5: begin
          nextState = ST_READ;
          if (cmdByte == CMD_SECTOR && !locked) begin
            strobe.capture = 1'b1;
            strobe.kind    = OP_SECTOR;
          end else if (cmdByte == CMD_CHIP && flags.atUnlockA && wpN) begin
            strobe.capture = 1'b1;
            strobe.kind    = OP_CHIP;
          end
        end
        ST_ID, ST_QUERY: if (cmdByte == CMD_EXIT) nextState = ST_READ;
        default:  nextState = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_READ;
      opAccept <= 1'b0;
    end else begin
      state    <= nextState;
      opAccept <= strobe.capture;
    end
  end

  assign inQuery      = (state == ST_QUERY);
  assign inIdMode     = (state == ST_ID);
  assign progPending  = (state == ST_PROG);
  assign erasePending = (state == ST_ERS3) || (state == ST_ERS4) || (state == ST_ERS5);

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int BOOT_WORDS = 32768,
  parameter int UNLOCK_A   = 'h555,
  parameter int UNLOCK_B   = 'h2AA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeValid,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              inQuery,
  output logic              inIdMode,
  output logic              progPending,
  output logic              erasePending,
  output logic              opAccept,
  output logic [1:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData
);

  dpStrobe_t  strobe;
  addrFlags_t flags;
  logic [7:0] cmdByte;

  nor_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobeValid(strobeValid),
    .ceN(ceN), .oeN(oeN), .weN(weN), .wpN(wpN),
    .flags(flags), .cmdByte(cmdByte), .strobe(strobe),
    .opAccept(opAccept), .inQuery(inQuery), .inIdMode(inIdMode),
    .progPending(progPending), .erasePending(erasePending)
  );

  nor_cmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_WORDS(BOOT_WORDS),
    .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .data(data),
    .strobe(strobe), .flags(flags), .cmdByte(cmdByte),
    .opAddr(opAddr), .opData(opData), .opKind(opKind)
  );

endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int BOOT_WORDS = 32768
) (
  input logic              clk,
  input logic              rstN,
  input logic              strobeValid,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              wpN,
  input logic [DATA_W-1:0] data,
  input logic              inQuery,
  input logic              inIdMode,
  input logic              progPending,
  input logic              erasePending,
  input logic              opAccept,
  input logic [1:0]        opKind,
  input logic [ADDR_W-1:0] opAddr
);

  localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'((64'd1 << ADDR_W) - 64'(BOOT_WORDS));

  logic takeWr;
  assign takeWr = strobeValid && !ceN && !weN && oeN;

  // R10: accept lasts one cycle
  a_r10_accept_single: assert property (@(posedge clk) disable iff (!rstN)
    opAccept |=> !opAccept);

  // R9: an unqualified cycle changes nothing and accepts nothing
  a_r9_inhibit_hold: assert property (@(posedge clk) disable iff (!rstN)
    !takeWr |=> $stable({inQuery, inIdMode, progPending, erasePending}) && !opAccept);

  // R8: nothing locked gets through while protect is low
  a_r8_boot_lock: assert property (@(posedge clk) disable iff (!rstN)
    opAccept |-> $past(wpN) || (opAddr < BOOT_BASE && opKind != 2'd2));

  // R5: modes are exclusive
  a_r5_modes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inQuery, inIdMode, progPending, erasePending}));

  // R2: accept only ends a pending sequence
  a_r2_accept_from_pending: assert property (@(posedge clk) disable iff (!rstN)
    opAccept |-> $past(progPending || erasePending));

  // R7: query survives non-exit writes
  a_r7_query_holds: assert property (@(posedge clk) disable iff (!rstN)
    inQuery && takeWr && data[7:0] != 8'hF0 |=> inQuery);

endmodule

bind nor_cmd_decoder nor_cmd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_WORDS(BOOT_WORDS)
) u_chk (
  .clk(clk), .rstN(rstN), .strobeValid(strobeValid), .ceN(ceN), .oeN(oeN),
  .weN(weN), .wpN(wpN), .data(data), .inQuery(inQuery), .inIdMode(inIdMode),
  .progPending(progPending), .erasePending(erasePending),
  .opAccept(opAccept), .opKind(opKind), .opAddr(opAddr)
);

// File: tb/nor_cmd_decoder_tb.sv
module nor_cmd_decoder_tb;

  localparam int M_READ = 0, M_U1 = 1, M_U2 = 2, M_PROG = 3, M_E3 = 4,
                 M_E4 = 5, M_E5 = 6, M_ID = 7, M_QRY = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic strobeValid = 1'b0, ceN = 1'b1, oeN = 1'b1, weN = 1'b1, wpN = 1'b1;
  logic [21:0] addr = '0;
  logic [15:0] data = '0;
  logic inQuery, inIdMode, progPending, erasePending, opAccept;
  logic [1:0] opKind;
  logic [21:0] opAddr;
  logic [15:0] opData;

  int checks = 0, failures = 0;
  int mState = M_READ;
  bit expAcc = 0;
  logic [1:0] expKind;
  logic [21:0] expAddr;
  logic [15:0] expData;

  always #2 clk = ~clk;

  nor_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .strobeValid(strobeValid), .ceN(ceN), .oeN(oeN),
    .weN(weN), .wpN(wpN), .addr(addr), .data(data), .inQuery(inQuery),
    .inIdMode(inIdMode), .progPending(progPending), .erasePending(erasePending),
    .opAccept(opAccept), .opKind(opKind), .opAddr(opAddr), .opData(opData)
  );

  function automatic logic [3:0] expModes(int s);
    return {s == M_QRY, s == M_ID, s == M_PROG, (s == M_E3 || s == M_E4 || s == M_E5)};
  endfunction

  function automatic bit isBoot(logic [21:0] a);
    return a >= 22'h3F8000;
  endfunction

  task automatic modelStep(logic [21:0] a, logic [15:0] d, bit ok, bit wp);
    logic [7:0] c = d[7:0];
    bit ka = (a == 22'h555) && (c == 8'hAA);
    bit kb = (a == 22'h2AA) && (c == 8'h55);
    expAcc = 0;
    if (!ok) return;
    case (mState)
      M_READ: if (ka) mState = M_U1;
      M_U1:   mState = kb ? M_U2 : M_READ;
      M_U2: begin
        mState = M_READ;
        if (a == 22'h555) begin
          if (c == 8'hA0) mState = M_PROG;
          else if (c == 8'h80) mState = M_E3;
          else if (c == 8'h90) mState = M_ID;
          else if (c == 8'h98) mState = M_QRY;
        end
      end
      M_PROG: begin
        mState = M_READ;
        if (wp || !isBoot(a)) begin expAcc = 1; expKind = 0; expAddr = a; expData = d; end
      end
      M_E3: mState = ka ? M_E4 : M_READ;
      M_E4: mState = kb ? M_E5 : M_READ;
      M_E5: begin
        mState = M_READ;
        if (c == 8'h30 && (wp || !isBoot(a))) begin
          expAcc = 1; expKind = 1; expAddr = a; expData = d;
        end else if (c == 8'h10 && a == 22'h555 && wp) begin
          expAcc = 1; expKind = 2; expAddr = a; expData = d;
        end
      end
      M_ID, M_QRY: if (c == 8'hF0) mState = M_READ;
      default: mState = M_READ;
    endcase
  endtask

  task automatic check(string tag);
    logic [3:0] m = {inQuery, inIdMode, progPending, erasePending};
    bit bad = (m != expModes(mState)) || (opAccept != expAcc);
    if (expAcc && (opAddr != expAddr || opKind != expKind || opData != expData)) bad = 1;
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s: modes=%b acc=%0b kind=%0d addr=%h data=%h expected modes=%b acc=%0b kind=%0d addr=%h data=%h",
               tag, m, opAccept, opKind, opAddr, opData, expModes(mState), expAcc,
               expKind, expAddr, expData);
    end
  endtask

  // drive one write at a falling edge, check one edge later
  task automatic wr(logic [21:0] a, logic [15:0] d, string tag,
                    bit wp = 1, logic c = 0, logic o = 1, logic w = 0);
    addr = a; data = d; wpN = wp; ceN = c; oeN = o; weN = w; strobeValid = 1;
    modelStep(a, d, (!c && !w && o), wp);
    @(negedge clk);
    strobeValid = 0; weN = 1;
    check(tag);
  endtask

  task automatic idle(string tag);
    expAcc = 0;
    @(negedge clk);
    check(tag);
  endtask

  task automatic doReset(string tag);
    rstN = 0; mState = M_READ; expAcc = 0;
    @(negedge clk);
    check(tag);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(tag);
  endtask

  task automatic unlock(string tag);
    wr(22'h555, 16'h00AA, tag);
    wr(22'h2AA, 16'h0055, tag);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset("R1 reset state");

    // R2 program
    unlock("R2"); wr(22'h555, 16'h00A0, "R2 program pending");
    wr(22'h001234, 16'hBEEF, "R2 program accept");
    idle("R10 accept one cycle");

    // R3 sector and chip erase
    unlock("R3"); wr(22'h555, 16'h0080, "R3 erase setup");
    unlock("R3 erase unlock2"); wr(22'h12345, 16'h0030, "R3 sector erase");
    idle("R10 accept drops");
    unlock("R3"); wr(22'h555, 16'h0080, "R3");
    unlock("R3"); wr(22'h555, 16'h1210, "R3 chip erase upper byte ignored R10");

    // R4 short erase
    unlock("R4"); wr(22'h555, 16'h0030, "R4 short sector refused");
    unlock("R4"); wr(22'h555, 16'h0010, "R4 short chip refused");

    // R5 broken sequences
    wr(22'h555, 16'h00AA, "R5"); wr(22'h2AA, 16'h0056, "R5 bad second cycle");
    unlock("R5"); wr(22'h555, 16'h0080, "R5");
    wr(22'h556, 16'h00AA, "R5 bad fourth cycle");
    wr(22'h2AA, 16'h0055, "R5 stays read");

    // R6 / R7 query and id
    unlock("R6"); wr(22'h555, 16'h0098, "R6 query entry");
    wr(22'h555, 16'h00AA, "R7 query holds");
    wr(22'h123456, 16'h00F0, "R7 query exit");
    unlock("R6"); wr(22'h555, 16'h0090, "R6 id entry");
    wr(22'h000010, 16'h0098, "R7 id holds");
    wr(22'h3FFFFF, 16'hABF0, "R7 id exit");

    // R8 boot protection
    unlock("R8"); wr(22'h555, 16'h00A0, "R8");
    wr(22'h3F8000, 16'h1111, "R8 boot base refused", 0);
    unlock("R8"); wr(22'h555, 16'h00A0, "R8");
    wr(22'h3F7FFF, 16'h2222, "R8 below boot accepted", 0);
    unlock("R8"); wr(22'h555, 16'h00A0, "R8");
    wr(22'h3FFFFF, 16'h3333, "R8 boot top refused", 0);
    unlock("R8"); wr(22'h555, 16'h0080, "R8"); unlock("R8");
    wr(22'h555, 16'h0010, "R8 chip erase refused", 0);
    unlock("R8"); wr(22'h555, 16'h0080, "R8"); unlock("R8");
    wr(22'h3F9000, 16'h0030, "R8 boot sector open", 1);

    // R9 inhibited cycles
    unlock("R9");
    wr(22'h555, 16'h00A0, "R9 oe low ignored", 1, 0, 0, 0);
    wr(22'h555, 16'h00A0, "R9 ce high ignored", 1, 1, 1, 0);
    wr(22'h555, 16'h00A0, "R9 we high ignored", 1, 0, 1, 1);
    wr(22'h555, 16'h00A0, "R9 valid after inhibits");
    wr(22'h000200, 16'h4444, "R9 program after inhibits", 1, 0, 0, 0);
    wr(22'h000200, 16'h4444, "R9 program completes");

    // R1 abort mid sequence
    unlock("R1"); wr(22'h555, 16'h0080, "R1"); unlock("R1");
    doReset("R1 reset aborts erase");
    wr(22'h000400, 16'h0030, "R1 no resume after reset");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [21:0] a = 22'($urandom);
      logic [15:0] d = 16'($urandom);
      int r = $urandom % 100;
      bit wp = ($urandom % 2) == 1;
      logic c = 0, o = 1, w = 0;
      if (r < 60) begin
        case (mState)
          M_READ, M_E3: begin a = 22'h555; d = 16'h00AA; end
          M_U1, M_E4:   begin a = 22'h2AA; d = 16'h0055; end
          M_U2: begin
            a = 22'h555;
            case ($urandom % 4)
              0: d = 16'h00A0; 1: d = 16'h0080; 2: d = 16'h0090; default: d = 16'h0098;
            endcase
          end
          M_PROG: if ($urandom % 3 == 0) a = 22'h3F8000 | 22'($urandom % 32768);
          M_E5: if ($urandom % 2 == 1) d = 16'h0030;
                else begin a = 22'h555; d = 16'h0010; end
          default: d = {d[15:8], 8'hF0};
        endcase
      end else if (r < 75) begin
        a = ($urandom % 2) ? 22'h555 : 22'h2AA;
      end
      if ($urandom % 10 == 0) begin
        c = 1'($urandom); o = 1'($urandom); w = 1'($urandom);
      end
      if ($urandom % 200 == 0) doReset("R1 random reset");
      else if ($urandom % 10 == 0) idle("R9 random idle");
      else wr(a, d, "R5 random model", wp, c, o, w);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule